// File: doc/BRIEF.md
# Strobe-Gated Serial-In Parallel-Out Output Driver

This block is a serial-in, parallel-out shift chain whose contents reach a bank of active-low outputs only while a strobe input is held high. On each rising edge of the shift clock, one bit enters the chain from a single serial input and every stored bit moves one position deeper. The outputs have no holding latch. Each output pulse has the width of the strobe pulse, and all outputs return high as soon as the strobe drops.

The chain is built from 8-bit stages. The last stage is presented, unmodified and ungated, on a cascade output, so that further copies of the block can be chained on the same clock and strobe. The parameter `STAGES` sets the number of 8-bit stages. This gives `8*STAGES` outputs with one serial input and one serial output.

Top module: `strobe_sipo_driver`

## Requirements
- R1: While `rst` is high at a rising clock edge, every chain bit is cleared to 0. From the next cycle onward, all of `out_n` read 1 and `cascade_out` reads 0, whatever the strobe does.
- R2: At each rising clock edge with `rst` low, `ser_in` is stored into chain bit 0, and chain bit j moves to bit j+1 for every j below the top bit.
- R3: While `strobe` is 1, `out_n[j]` is 0 exactly when chain bit j holds 1, and 1 when it holds 0 (active-low encoding).
- R4: While `strobe` is 0, every bit of `out_n` is 1, whatever the chain holds.
- R5: Raising or lowering `strobe` never changes the stored bits. After any strobe activity, the chain contents equal what the shift history alone predicts.
- R6: `strobe` acts on `out_n` without a clock, with no latching. A change of strobe within a cycle shows on the outputs in that same cycle. A shift made while strobe is high shows on the outputs right after the edge.
- R7: `cascade_out` always equals the top chain bit (index 8*STAGES-1). It is not inverted and does not depend on `strobe`.
- R8: Stages are joined so that bit 7 of stage s feeds bit 0 of stage s+1. A bit entering on `ser_in` reaches `cascade_out` after exactly 8*STAGES rising edges.
- R9: Output index follows chain position. `out_n[0]` is the stage nearest `ser_in`, and `out_n[8*STAGES-1]` is the stage that also drives `cascade_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; data is taken on the rising edge |
| rst | input | 1 | Synchronous active-high clear of the chain |
| ser_in | input | 1 | Serial data into chain bit 0 |
| strobe | input | 1 | Enables the active-low outputs while high |
| out_n | output | 8*STAGES | Active-low parallel outputs, gated by strobe |
| cascade_out | output | 1 | Top chain bit, for the next device's serial input |

## Verification
The chain is filled with an irregular word while the strobe is low. This shows that the outputs stay high and that the cascade bit still moves. A single 1 is then walked through all positions with the strobe high, which exposes any wrong bit order, stage link or output polarity. Solid ones and solid zeros separate a stuck output from a real mapping fault. A strobe pulse that rises and falls within one clock low phase shows that gating is combinational and that it leaves the stored bits alone.

// File: rtl/strobe_sipo_pkg.sv
`timescale 1ns/1ps
package strobe_sipo_pkg;
  localparam int unsigned STAGE_BITS = 8;

  function automatic int unsigned chain_width(input int unsigned stages);
    return stages * STAGE_BITS;
  endfunction

  // Active-low drive level for one output: low only when enabled and set.
  function automatic logic drive_level(input logic stored, input logic enable);
    return !(stored && enable);
  endfunction
endpackage

// File: rtl/sipo_stage.sv
`timescale 1ns/1ps
module sipo_stage #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  output logic [WIDTH-1:0] q,
  output logic             dout
);
  logic [WIDTH-1:0] bits_q;
  logic [WIDTH-1:0] bits_d;

  generate
    if (WIDTH > 1) begin : g_multi
      always_comb bits_d = {bits_q[WIDTH-2:0], din};
    end else begin : g_single
      always_comb bits_d = din;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) bits_q <= '0;
    else     bits_q <= bits_d;
  end

  assign q    = bits_q;
  assign dout = bits_q[WIDTH-1];

  // R2: newest bit lands in position 0
  a_r2_capture_input: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> bits_q[0] == $past(din));

  generate
    if (WIDTH > 1) begin : g_shift_chk
      // R2: every other bit moves up by one
      a_r2_shift_up: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> bits_q[WIDTH-1:1] == $past(bits_q[WIDTH-2:0]));
    end
  endgenerate
endmodule

// File: rtl/strobe_gate.sv
`timescale 1ns/1ps
module strobe_gate
  import strobe_sipo_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             strobe,
  input  logic [WIDTH-1:0] bits,
  output logic [WIDTH-1:0] out_n
);
  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      assign out_n[i] = drive_level(bits[i], strobe);
    end
  endgenerate

  // R4: with the strobe low nothing is driven
  always_comb begin
    if (strobe === 1'b0) begin
      a_r4_idle_high: assert (out_n == {WIDTH{1'b1}});
    end
  end
endmodule

// File: rtl/strobe_sipo_driver.sv
`timescale 1ns/1ps
module strobe_sipo_driver
  import strobe_sipo_pkg::*;
#(
  parameter int unsigned STAGES = 1
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            ser_in,
  input  logic                            strobe,
  output logic [STAGE_BITS*STAGES-1:0]    out_n,
  output logic                            cascade_out
);
  localparam int unsigned TOTAL = chain_width(STAGES);

  logic [TOTAL-1:0]  chain_q;
  logic [STAGES:0]   link;

  assign link[0] = ser_in;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      sipo_stage #(.WIDTH(STAGE_BITS)) u_stage (
        .clk  (clk),
        .rst  (rst),
        .din  (link[s]),
        .q    (chain_q[s*STAGE_BITS +: STAGE_BITS]),
        .dout (link[s+1])
      );
    end
  endgenerate

  strobe_gate #(.WIDTH(TOTAL)) u_gate (
    .strobe (strobe),
    .bits   (chain_q),
    .out_n  (out_n)
  );

  assign cascade_out = link[STAGES];

  // R1: a reset cycle leaves everything inactive
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (out_n == {TOTAL{1'b1}}) && !cascade_out);

  // R5: stored bits follow the shift history no matter what the strobe did
  a_r5_strobe_keeps_bits: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> chain_q[TOTAL-1:1] == $past(chain_q[TOTAL-2:0]));

  // R7: cascade carries the bit just below the top one, one edge later
  a_r7_cascade_moves: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cascade_out == $past(chain_q[TOTAL-2]));

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_link_chk
      // R8: the top of stage s-1 feeds the bottom of stage s
      a_r8_stage_link: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> chain_q[s*STAGE_BITS] == $past(chain_q[s*STAGE_BITS-1]));
    end
  endgenerate
endmodule

// File: tb/strobe_sipo_driver_test.sv
`timescale 1ns/1ps
module strobe_sipo_driver_test;
  localparam int STAGES = 2;
  localparam int W = 8 * STAGES;

  typedef struct {
    logic [W-1:0] out_n;
    logic         casc;
    string        req;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_in = 1'b0;
  logic strobe = 1'b0;
  logic [W-1:0] out_n;
  logic cascade_out;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [W-1:0] model = '0;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  strobe_sipo_driver #(.STAGES(STAGES)) uut (
    .clk(clk), .rst(rst), .ser_in(ser_in), .strobe(strobe),
    .out_n(out_n), .cascade_out(cascade_out)
  );

  function automatic logic [W-1:0] gate_model(logic [W-1:0] m, logic s);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = (s && m[i]) ? 1'b0 : 1'b1;
    return r;
  endfunction

  task automatic compare(logic [W-1:0] got_o, logic got_c, exp_t e);
    checks++;
    if (got_o !== e.out_n || got_c !== e.casc) begin
      failures++;
      $display("FAIL %s: out_n=%h cascade=%b expected out_n=%h cascade=%b",
               e.req, got_o, got_c, e.out_n, e.casc);
    end
  endtask

  // Driver: one clock per call; predicts the state after the coming edge.
  task automatic step(logic r, logic d, logic s, string req);
    exp_t e;
    @(negedge clk);
    rst = r; ser_in = d; strobe = s;
    if (r) model = '0;
    else   model = {model[W-2:0], d};
    e.out_n = gate_model(model, s);
    e.casc  = model[W-1];
    e.req   = req;
    exp_q.push_back(e);
  endtask

  // Strobe pulse inside one low phase, checked directly at the ports.
  task automatic short_pulse(logic d);
    exp_t e;
    @(negedge clk);
    rst = 1'b0; ser_in = d; strobe = 1'b1;
    #0.5;
    e.out_n = gate_model(model, 1'b1); e.casc = model[W-1]; e.req = "R6";
    compare(out_n, cascade_out, e);
    strobe = 1'b0;
    #0.5;
    e.out_n = '1; e.req = "R4";
    compare(out_n, cascade_out, e);
    model = {model[W-2:0], d};
    e.out_n = '1; e.casc = model[W-1]; e.req = "R5";
    exp_q.push_back(e);
  endtask

  // Monitor: pops one expectation per clock, shortly after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        compare(out_n, cascade_out, e);
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] word;
    // R1: reset with strobe high and data high still leaves outputs idle
    step(1, 1, 1, "R1");
    step(1, 1, 1, "R1");
    // R4 and R7: fill with an irregular word while strobe is low
    word = 16'hA5C3;
    for (int i = W - 1; i >= 0; i--) step(0, word[i], 0, "R4_R7");
    // R3 and R9: the word is now shown with strobe high
    step(0, 0, 1, "R3_R9");
    // R1: reset mid-run clears the chain and the cascade
    step(1, 0, 1, "R1");
    // R2, R8, R9: walk a single 1 through every position to the cascade
    step(0, 1, 1, "R2_R8");
    for (int i = 0; i < W; i++) step(0, 0, 1, "R2_R8_R9");
    // R3: solid ones then solid zeros with strobe high
    for (int i = 0; i < W; i++) step(0, 1, 1, "R3");
    for (int i = 0; i < W; i++) step(0, 0, 1, "R3");
    // R6 and R5: load a pattern, then short pulses within one low phase
    word = 16'h3C69;
    for (int i = W - 1; i >= 0; i--) step(0, word[i], 0, "R7");
    for (int i = 0; i < 4; i++) short_pulse(logic'(i & 1));
    // R5 and R6: toggle the strobe on alternate clocks while shifting
    for (int i = 0; i < W; i++) step(0, logic'(i % 3 == 0), logic'(i & 1), "R5_R6");
    step(0, 0, 0, "R4");
    @(posedge clk);
    #2;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule